// File: doc/BRIEF.md
# Output Impedance Update Sequencer

This block keeps the code that sets the strength of a memory's data output drivers and moves that code toward a target produced by an external calibration circuit. The driver strength must never change while the data outputs are driving a read, so the block only steps the code in cycles where the outputs are in high impedance. Write cycles and deselected cycles always count as such windows. A cycle in which the outputs are turned off by the output-enable pin counts only when that pin was stable across the clock edge.

After reset the applied code is the minimum-impedance (strongest) setting, code 0. In each open window the code moves by exactly one step toward the target, so a full-range move needs at most 2^W - 1 window cycles. If the calibration pin is open or tied to its supply, the block uses the maximum-impedance code (all ones) as its target. A done flag shows that the applied code equals the target currently in effect.

Top module: `zq_update_seq`

## Requirements
- R1: While the reset is asserted, and after reset until a window opens, `drv_code` is 0, which is the minimum-impedance code.
- R2: In a cycle where no update window is open, `drv_code` keeps its value even if `cal_code` or `cal_pin_open` changes.
- R3: A cycle with `wr_cyc`=1 is an update window.
- R4: A cycle with `desel_cyc`=1 is an update window.
- R5: A cycle with `oe_off`=1 is an update window only if `oe_timed`=1 in the same cycle. When `oe_timed`=0, `oe_off` has no effect.
- R6: In a window, `drv_code` moves by exactly one toward the effective target at the next clock edge. It goes up when below the target and down when above it.
- R7: While `cal_pin_open`=1 the effective target is the all-ones (maximum-impedance) code and `cal_code` is ignored.
- R8: Starting from code 0, a move to the all-ones code finishes after exactly 2^W-1 window cycles, which is well inside a budget of 2048 window cycles.
- R9: `cal_done` is 1 exactly when `drv_code` equals the effective target, and is evaluated in the same cycle.
- R10: When `drv_code` equals the target, later windows leave it unchanged, so there is no overshoot or oscillation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| cal_code | input | W (7) | Target code from the calibration circuit |
| cal_pin_open | input | 1 | Calibration pin open or supply-tied; selects the maximum-impedance code |
| wr_cyc | input | 1 | Current cycle is a write |
| desel_cyc | input | 1 | Current cycle is deselected |
| oe_off | input | 1 | Output enable is inactive |
| oe_timed | input | 1 | Output enable met setup and hold around this clock edge |
| drv_code | output | W (7) | Applied driver impedance code |
| cal_done | output | 1 | Applied code equals the effective target |

## Verification
Two functions can coincide in one cycle: a change of target, and the opening or closing of an update window. The bench produces this by changing `cal_code` and `cal_pin_open` in the same cycle that a write, a deselect or a timed output-disable starts or stops. It also changes the target during cycles with no window. A behavioural model checks on every clock that the code moves only in window cycles, moves only one step, moves toward the target in force at that edge, and that `cal_done` follows the new target in the same cycle.

// File: rtl/zq_pkg.sv
package zq_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/zq_rst_sync.sv
module zq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/zq_window.sv
module zq_window (
  input  logic wr_cyc,
  input  logic desel_cyc,
  input  logic oe_off,
  input  logic oe_timed,
  output logic upd_win
);
  logic oe_win;

  always_comb begin
    oe_win  = oe_off & oe_timed;
    upd_win = wr_cyc | desel_cyc | oe_win;
  end
endmodule

// File: rtl/zq_target.sv
module zq_target #(
  parameter int W = 7
) (
  input  logic [W-1:0] cal_code,
  input  logic         cal_pin_open,
  output logic [W-1:0] eff_tgt
);
  localparam logic [W-1:0] MaxImp = {W{1'b1}};

  always_comb begin
    eff_tgt = cal_pin_open ? MaxImp : cal_code;
  end
endmodule

// File: rtl/zq_stepper.sv
module zq_stepper
  import zq_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_win,
  input  logic [W-1:0] eff_tgt,
  output logic [W-1:0] code_q,
  output logic         at_tgt
);
  localparam logic [W-1:0] MinImp = '0;
  localparam logic [W-1:0] OneStep = {{(W-1){1'b0}}, 1'b1};

  step_dir_e   dir;
  logic        code_en;
  logic [W-1:0] code_nxt;

  always_comb begin
    if (code_q < eff_tgt)      dir = STEP_UP;
    else if (code_q > eff_tgt) dir = STEP_DOWN;
    else                       dir = STEP_HOLD;
    code_en  = upd_win && (dir != STEP_HOLD);
    code_nxt = (dir == STEP_UP) ? code_q + OneStep : code_q - OneStep;
    at_tgt   = (dir == STEP_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= MinImp;
    else if (code_en) code_q <= code_nxt;
  end
endmodule

// File: rtl/zq_update_seq.sv
module zq_update_seq #(
  parameter int W          = 7,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cal_code,
  input  logic         cal_pin_open,
  input  logic         wr_cyc,
  input  logic         desel_cyc,
  input  logic         oe_off,
  input  logic         oe_timed,
  output logic [W-1:0] drv_code,
  output logic         cal_done
);
  logic         rst_core_n;
  logic         upd_win;
  logic [W-1:0] eff_tgt;

  zq_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  zq_window u_win (
    .wr_cyc    (wr_cyc),
    .desel_cyc (desel_cyc),
    .oe_off    (oe_off),
    .oe_timed  (oe_timed),
    .upd_win   (upd_win)
  );

  zq_target #(.W(W)) u_tgt (
    .cal_code     (cal_code),
    .cal_pin_open (cal_pin_open),
    .eff_tgt      (eff_tgt)
  );

  zq_stepper #(.W(W)) u_step (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .upd_win (upd_win),
    .eff_tgt (eff_tgt),
    .code_q  (drv_code),
    .at_tgt  (cal_done)
  );
endmodule

// File: rtl/zq_update_seq_chk.sv
module zq_update_seq_chk #(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         core_rst_n,
  input logic [W-1:0] cal_code,
  input logic         cal_pin_open,
  input logic         wr_cyc,
  input logic         desel_cyc,
  input logic         oe_off,
  input logic         oe_timed,
  input logic [W-1:0] drv_code,
  input logic         cal_done
);
  logic         win_c;
  logic [W-1:0] tgt_c;

  always_comb begin
    win_c = wr_cyc || desel_cyc || (oe_off && oe_timed);
    tgt_c = cal_pin_open ? {W{1'b1}} : cal_code;
  end

  AST_RESET_MIN: assert property (@(posedge clk) !rst_n |-> drv_code == '0); // R1

  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!core_rst_n)
    !win_c |=> $stable(drv_code)); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!core_rst_n)
    (win_c && drv_code < tgt_c) |=> drv_code == $past(drv_code) + 1'b1); // R6

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!core_rst_n)
    (win_c && drv_code > tgt_c) |=> drv_code == $past(drv_code) - 1'b1); // R6

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!core_rst_n)
    (drv_code == tgt_c) |=> $stable(drv_code)); // R10

  AST_DONE_MATCH: assert property (@(posedge clk) disable iff (!core_rst_n)
    cal_done == (drv_code == tgt_c)); // R9
endmodule

bind zq_update_seq zq_update_seq_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_rst_n   (rst_core_n),
  .cal_code     (cal_code),
  .cal_pin_open (cal_pin_open),
  .wr_cyc       (wr_cyc),
  .desel_cyc    (desel_cyc),
  .oe_off       (oe_off),
  .oe_timed     (oe_timed),
  .drv_code     (drv_code),
  .cal_done     (cal_done)
);

// File: tb/test_zq_update_seq.sv
module test_zq_update_seq;
  localparam int W = 7;
  localparam int MAXC = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cal_code = '0;
  logic         cal_pin_open = 1'b0;
  logic         wr_cyc = 1'b0, desel_cyc = 1'b0, oe_off = 1'b0, oe_timed = 1'b0;
  logic [W-1:0] drv_code;
  logic         cal_done;

  int total = 0;
  int bad = 0;
  int m_code = 0;
  int m_rel = 0;
  string phase = "R1";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  zq_update_seq i_zq_update_seq (
    .clk(clk), .rst_n(rst_n), .cal_code(cal_code), .cal_pin_open(cal_pin_open),
    .wr_cyc(wr_cyc), .desel_cyc(desel_cyc), .oe_off(oe_off), .oe_timed(oe_timed),
    .drv_code(drv_code), .cal_done(cal_done)
  );

  function automatic int eff_target();
    return cal_pin_open ? MAXC : int'(cal_code);
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0;
      m_rel  = 0;
    end else begin
      if (m_rel >= 3 && (wr_cyc || desel_cyc || (oe_off && oe_timed))) begin
        if (m_code < eff_target()) m_code = m_code + 1;
        else if (m_code > eff_target()) m_code = m_code - 1;
      end
      if (m_rel < 3) m_rel = m_rel + 1;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check({phase, " code"}, int'(drv_code), m_code);
      check({phase, " R9 done"}, int'(cal_done), int'(m_code == eff_target()));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic set_win(input bit w, input bit d, input bit o, input bit t);
    wr_cyc = w; desel_cyc = d; oe_off = o; oe_timed = t;
  endtask

  initial begin
    fork
      begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: got hang expected finish");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    // R1: reset state, min impedance
    cal_code = 7'd5;
    cyc(3);
    check("R1 reset code", int'(drv_code), 0);
    @(negedge clk); #1 rst_n = 1'b1;
    cyc(5);
    check("R1 post-reset code", int'(drv_code), 0);

    // R2: target moves, no window
    phase = "R2";
    cal_code = 7'd10; cyc(2);
    cal_code = 7'd90; cyc(2);
    cal_pin_open = 1'b1; cyc(2);
    cal_pin_open = 1'b0; cal_code = 7'd10; cyc(1);
    check("R2 closed hold", int'(drv_code), 0);

    // R3: writes, window opens with target change in same cycle
    phase = "R3";
    set_win(1, 0, 0, 0); cyc(3);
    set_win(0, 0, 0, 0); cyc(1);
    check("R3 write steps", int'(drv_code), 3);

    // R4: deselect
    phase = "R4";
    set_win(0, 1, 0, 0); cyc(4);
    set_win(0, 0, 0, 0); cyc(1);
    check("R4 deselect steps", int'(drv_code), 7);

    // R5: untimed output disable ignored, timed one counts
    phase = "R5";
    set_win(0, 0, 1, 0); cyc(4);
    check("R5 untimed ignored", int'(drv_code), 7);
    set_win(0, 0, 1, 1); cyc(3);
    set_win(0, 0, 0, 0); cyc(1);
    check("R5 timed steps", int'(drv_code), 10);
    check("R9 done at target", int'(cal_done), 1);

    // R10: no overshoot
    phase = "R10";
    set_win(1, 1, 0, 0); cyc(5);
    check("R10 hold at target", int'(drv_code), 10);

    // R6: step down, target swapped mid-window
    phase = "R6";
    cal_code = 7'd4; cyc(3);
    check("R6 downward step", int'(drv_code), 7);
    cal_code = 7'd20; cyc(2);
    check("R6 reverse step", int'(drv_code), 9);
    set_win(0, 0, 0, 0); cal_code = 7'd4; cyc(2);
    check("R2 closed after window", int'(drv_code), 9);

    // R7/R8: open pin gives max code, full range from 0 within budget
    phase = "R7";
    rst_n = 1'b0; cyc(2);
    check("R1 re-reset code", int'(drv_code), 0);
    rst_n = 1'b1; cyc(5);
    cal_pin_open = 1'b1; cal_code = 7'd3;
    check("R7 done low at open", int'(cal_done), 0);
    phase = "R8";
    begin
      int n = 0;
      set_win(1, 0, 0, 0);
      while (!cal_done && n < 2048) begin
        cyc(1);
        n++;
      end
      set_win(0, 0, 0, 0);
      check("R8 window cycles", n, MAXC);
      check("R7 max code", int'(drv_code), MAXC);
    end
    cyc(2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule